// File: doc/BRIEF.md
# JTAG debug transaction sequencer

This block is a host-side engine that turns debug-port register commands into JTAG data-register scans. A command names a debug-port (DP) or access-port (AP) register, a direction and, for writes, a 32-bit value. The engine writes the bank-select register before an AP access only when the register bank differs from the last one it wrote. It issues the access scan. For a read, it then issues a read-buffer scan, because the access scan returns only the posted result of the previous operation. The read data comes back with the completion pulse.

A batch of commands ends with a check command. The check posts a control/status read and collects it through the read-buffer scan. While the acknowledge says WAIT, it repeats that pair until a cycle-count timeout runs out. Once the acknowledge is OK, it inspects the sticky overrun and sticky error flags. When a flag is set and debug power is not fully up, the engine asks for a port re-initialisation. When a flag is set and power is up, it clears the flags, reads control/status again, and reads the AP control word and address register for diagnosis. In both cases it reports an error.

The bit-level TCK/TMS shifter sits outside the block. The engine drives it through a request port that carries the instruction code, the 3-bit address/direction field, the 32-bit data and a count of extra idle TCK cycles. The shifter answers with a one-cycle completion that carries the 3-bit acknowledge and the captured data.

Top module: `dbg_txn_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `scan_req` and `done` are 0. The cached bank is invalid, so the first AP command always writes the bank-select register.
- R2: A DP write (`cmd_op`=1) issues exactly one scan with instruction 4'hA, field {addr[3:2],1'b0} and the command data. It then pulses `done` with `err`=0.
- R3: A read (`cmd_op`=0 for DP, 2 for AP) issues its access scan with field {addr[3:2],1'b1} and data 0. A read-buffer scan follows (instruction 4'hA, field 3'b111). The data captured by that second scan appears on `rdata` while `done` is high.
- R4: An AP command (`cmd_op`=2 or 3) uses instruction 4'hB. The access scan is preceded by a bank-select write (instruction 4'hA, field 3'b100, data {ap_sel,16'h0,addr[7:4],4'h0}) only when addr[7:4] differs from the bank last written.
- R5: An AP access scan to address 8'h0C, or to any address in 8'h10–8'h1F, carries `scan_idle`=MEM_IDLE. Every other scan carries 0.
- R6: A check (`cmd_op`=4) issues a control/status read (instruction 4'hA, field 3'b011) and then a read-buffer scan. When that scan's acknowledge is 3'b010 and bits 1 and 5 of its data are both 0, `done` pulses with `err`=0.
- R7: When the read-buffer acknowledge is 3'b001 (WAIT), the pair is reissued. Once TIMEOUT_CYC cycles have passed since the check was accepted, a WAIT instead ends the check with `done` and `err`=1.
- R8: Any read-buffer acknowledge other than 3'b010 or 3'b001 ends the check at once with `done` and `err`=1, and no further scan is issued.
- R9: When the acknowledge is OK, bit 1 or bit 5 is set, and bits 31:28 are not all ones, the check ends with `done`, `err` and `reinit_req` all high.
- R10: When a sticky bit is set and bits 31:28 are all ones, the engine issues these scans in order, then ends with `done` and `err`=1:
  - a control/status write (field 3'b010, data = read value | 32'h22);
  - the control/status read pair;
  - a bank-select write of bank 0, only when bank 0 is not cached;
  - an AP read of 8'h00 (field 3'b001) followed by a read-buffer scan;
  - an AP read of 8'h04 (field 3'b011) followed by a read-buffer scan.
- R11: Op codes 5 to 7 issue no scan and end with `done` and `err`=1.
- R12: While `scan_req` is high and `scan_done` is low, all scan fields hold steady. `done` never coincides with `scan_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 3 | 0 DP read, 1 DP write, 2 AP read, 3 AP write, 4 check |
| cmd_addr | input | 8 | Register address; bits 7:4 select the AP bank |
| cmd_wdata | input | 32 | Write data |
| ap_sel | input | 8 | AP number placed in the bank-select word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status, valid with `done` |
| reinit_req | output | 1 | Port re-initialisation request, valid with `done` |
| rdata | output | 32 | Read result, valid with `done` after a read |
| scan_req | output | 1 | Scan request to the shifter |
| scan_ir | output | 4 | Instruction for the scan |
| scan_field | output | 3 | Address/direction field |
| scan_wdata | output | 32 | Data shifted out |
| scan_idle | output | IDLE_W | Extra idle TCK cycles after the scan |
| scan_done | input | 1 | Shifter completion pulse |
| scan_ack | input | 3 | Acknowledge captured by the scan |
| scan_rdata | input | 32 | Data captured by the scan |

## Verification
The assertions watch four things on every cycle:
- the request fields hold while the shifter works;
- `done` never overlaps a scan request or a busy engine;
- a re-initialisation request always comes with an error completion;
- nonzero idle padding appears only on AP scans.

Three behaviours show only in the bench's scenarios, where a scoreboard compares each scan in turn against the expected sequence:
- the order and content of the scans, including skipped bank-select writes and the diagnostic reads after a sticky error;
- the WAIT retry loop and its timeout;
- the cache state carried from one command to the next.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_ACC, ST_RDB,
    ST_CK_POST, ST_CK_RDB,
    ST_CLR_WR, ST_CLR_POST, ST_CLR_RDB,
    ST_DG_SEL, ST_DG_CSW, ST_DG_RB1, ST_DG_TAR, ST_DG_RB2
  } seq_st_e;

  localparam logic [3:0] IR_DPACC = 4'hA;
  localparam logic [3:0] IR_APACC = 4'hB;

  localparam logic [2:0] ACK_OKF  = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  localparam logic [2:0] OP_DP_RD = 3'd0;
  localparam logic [2:0] OP_DP_WR = 3'd1;
  localparam logic [2:0] OP_AP_RD = 3'd2;
  localparam logic [2:0] OP_AP_WR = 3'd3;
  localparam logic [2:0] OP_CHECK = 3'd4;

  localparam logic [2:0] FLD_SEL_WR  = 3'b100;
  localparam logic [2:0] FLD_CTRL_RD = 3'b011;
  localparam logic [2:0] FLD_CTRL_WR = 3'b010;
  localparam logic [2:0] FLD_RBUF_RD = 3'b111;
  localparam logic [2:0] FLD_CSW_RD  = 3'b001;
  localparam logic [2:0] FLD_TAR_RD  = 3'b011;

  localparam logic [31:0] STICKY_BITS = 32'h0000_0022;
endpackage

// File: rtl/dbg_bank_cache.sv
module dbg_bank_cache #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [BANK_W-1:0] q_bank,
  output logic              hit
);
  logic              vld_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      bank_q <= '0;
    end else if (upd) begin
      vld_q  <= 1'b1;
      bank_q <= upd_bank;
    end
  end

  assign hit = vld_q && (bank_q == q_bank);
endmodule

// File: rtl/dbg_wait_timer.sv
module dbg_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt_q;

  assign expired = (cnt_q >= TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dbg_scan_fmt.sv
module dbg_scan_fmt
  import dbg_seq_pkg::*;
#(
  parameter int MEM_IDLE = 8,
  parameter int IDLE_W   = 4
) (
  input  seq_st_e            st,
  input  logic [2:0]         op_q,
  input  logic [7:0]         addr_q,
  input  logic [31:0]        wdata_q,
  input  logic [7:0]         ap_sel,
  input  logic [31:0]        ctrl_q,
  output logic               active,
  output logic [3:0]         ir,
  output logic [2:0]         fld,
  output logic [31:0]        wd,
  output logic [IDLE_W-1:0]  idle
);
  logic rnw, is_ap, mem_hit;

  assign rnw     = (op_q == OP_DP_RD) || (op_q == OP_AP_RD);
  assign is_ap   = (op_q == OP_AP_RD) || (op_q == OP_AP_WR);
  assign mem_hit = (addr_q == 8'h0C) || (addr_q[7:4] == 4'h1);

  always_comb begin
    active = 1'b1;
    ir     = IR_DPACC;
    fld    = FLD_RBUF_RD;
    wd     = '0;
    idle   = '0;
    case (st)
      ST_SEL:    begin fld = FLD_SEL_WR; wd = {ap_sel, 16'h0, addr_q[7:4], 4'h0}; end
      ST_ACC: begin
        ir  = is_ap ? IR_APACC : IR_DPACC;
        fld = {addr_q[3:2], rnw};
        wd  = rnw ? 32'h0 : wdata_q;
        if (is_ap && mem_hit) idle = IDLE_W'(MEM_IDLE);
      end
      ST_RDB, ST_CK_RDB, ST_CLR_RDB, ST_DG_RB1, ST_DG_RB2: fld = FLD_RBUF_RD;
      ST_CK_POST, ST_CLR_POST: fld = FLD_CTRL_RD;
      ST_CLR_WR: begin fld = FLD_CTRL_WR; wd = ctrl_q | STICKY_BITS; end
      ST_DG_SEL: begin fld = FLD_SEL_WR; wd = {ap_sel, 24'h0}; end
      ST_DG_CSW: begin ir = IR_APACC; fld = FLD_CSW_RD; end
      ST_DG_TAR: begin ir = IR_APACC; fld = FLD_TAR_RD; end
      default:   active = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_txn_seq.sv
module dbg_txn_seq
  import dbg_seq_pkg::*;
#(
  parameter int MEM_IDLE    = 8,
  parameter int TIMEOUT_CYC = 50_000_000,
  parameter int IDLE_W      = $clog2(MEM_IDLE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        cmd_addr,
  input  logic [31:0]       cmd_wdata,
  input  logic [7:0]        ap_sel,
  output logic              done,
  output logic              err,
  output logic              reinit_req,
  output logic [31:0]       rdata,
  output logic              scan_req,
  output logic [3:0]        scan_ir,
  output logic [2:0]        scan_field,
  output logic [31:0]       scan_wdata,
  output logic [IDLE_W-1:0] scan_idle,
  input  logic              scan_done,
  input  logic [2:0]        scan_ack,
  input  logic [31:0]       scan_rdata
);
  seq_st_e     st;
  logic [2:0]  op_q;
  logic [7:0]  addr_q;
  logic [31:0] wdata_q, ctrl_q;
  logic        bank_hit, bank_upd, tmo;
  logic [3:0]  q_bank, upd_bank;
  logic        op_rnw, sticky, pwr_on;

  assign cmd_ready = (st == ST_IDLE);
  assign op_rnw    = (op_q == OP_DP_RD) || (op_q == OP_AP_RD);
  assign sticky    = scan_rdata[1] | scan_rdata[5];
  assign pwr_on    = &scan_rdata[31:28];
  assign q_bank    = (st == ST_IDLE) ? cmd_addr[7:4] : 4'h0;
  assign bank_upd  = scan_done && ((st == ST_SEL) || (st == ST_DG_SEL));
  assign upd_bank  = (st == ST_SEL) ? addr_q[7:4] : 4'h0;

  dbg_bank_cache #(.BANK_W(4)) u_bank (
    .clk(clk), .rst(rst), .upd(bank_upd), .upd_bank(upd_bank),
    .q_bank(q_bank), .hit(bank_hit)
  );

  dbg_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst(rst), .clr(st == ST_IDLE), .expired(tmo)
  );

  dbg_scan_fmt #(.MEM_IDLE(MEM_IDLE), .IDLE_W(IDLE_W)) u_fmt (
    .st(st), .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .ap_sel(ap_sel), .ctrl_q(ctrl_q), .active(scan_req), .ir(scan_ir),
    .fld(scan_field), .wd(scan_wdata), .idle(scan_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      ctrl_q     <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      reinit_req <= 1'b0;
      rdata      <= '0;
    end else begin
      done       <= 1'b0;
      err        <= 1'b0;
      reinit_req <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          case (cmd_op)
            OP_DP_RD, OP_DP_WR: st <= ST_ACC;
            OP_AP_RD, OP_AP_WR: st <= bank_hit ? ST_ACC : ST_SEL;
            OP_CHECK:           st <= ST_CK_POST;
            default: begin done <= 1'b1; err <= 1'b1; end
          endcase
        end
        ST_SEL: if (scan_done) st <= ST_ACC;
        ST_ACC: if (scan_done) begin
          if (op_rnw) st <= ST_RDB;
          else begin st <= ST_IDLE; done <= 1'b1; end
        end
        ST_RDB: if (scan_done) begin
          rdata <= scan_rdata;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_CK_POST: if (scan_done) st <= ST_CK_RDB;
        ST_CK_RDB: if (scan_done) begin
          if (scan_ack == ACK_OKF) begin
            ctrl_q <= scan_rdata;
            if (sticky && pwr_on) st <= ST_CLR_WR;
            else begin
              st         <= ST_IDLE;
              done       <= 1'b1;
              err        <= sticky;
              reinit_req <= sticky;
            end
          end else if ((scan_ack == ACK_WAIT) && !tmo) begin
            st <= ST_CK_POST;
          end else begin
            st <= ST_IDLE; done <= 1'b1; err <= 1'b1;
          end
        end
        ST_CLR_WR:   if (scan_done) st <= ST_CLR_POST;
        ST_CLR_POST: if (scan_done) st <= ST_CLR_RDB;
        ST_CLR_RDB:  if (scan_done) st <= bank_hit ? ST_DG_CSW : ST_DG_SEL;
        ST_DG_SEL:   if (scan_done) st <= ST_DG_CSW;
        ST_DG_CSW:   if (scan_done) st <= ST_DG_RB1;
        ST_DG_RB1:   if (scan_done) st <= ST_DG_TAR;
        ST_DG_TAR:   if (scan_done) st <= ST_DG_RB2;
        ST_DG_RB2:   if (scan_done) begin
          st <= ST_IDLE; done <= 1'b1; err <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg_txn_seq_chk.sv
module dbg_txn_seq_chk #(
  parameter int IDLE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              scan_req,
  input logic [3:0]        scan_ir,
  input logic [2:0]        scan_field,
  input logic [31:0]       scan_wdata,
  input logic [IDLE_W-1:0] scan_idle,
  input logic              scan_done,
  input logic              done,
  input logic              err,
  input logic              reinit_req
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    scan_req && !scan_done |=> scan_req && $stable(scan_ir) && $stable(scan_field)
                               && $stable(scan_wdata) && $stable(scan_idle));
  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !scan_req && cmd_ready);
  // R9
  reinit_err_chk: assert property (@(posedge clk) disable iff (rst)
    reinit_req |-> done && err);
  // R5
  idle_ap_chk: assert property (@(posedge clk) disable iff (rst)
    scan_req && (scan_idle != '0) |-> scan_ir == 4'hB);
  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !scan_req);
endmodule

bind dbg_txn_seq dbg_txn_seq_chk #(.IDLE_W(IDLE_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .scan_req(scan_req),
  .scan_ir(scan_ir), .scan_field(scan_field), .scan_wdata(scan_wdata),
  .scan_idle(scan_idle), .scan_done(scan_done), .done(done), .err(err),
  .reinit_req(reinit_req)
);

// File: tb/test_dbg_txn_seq.sv
module test_dbg_txn_seq;
  localparam int MIDLE = 5;
  localparam int BW    = $clog2(MIDLE + 1);

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_op = 0;
  logic [7:0] cmd_addr = 0;
  logic [31:0] cmd_wdata = 0;
  logic [7:0] ap_sel = 8'h03;
  logic done, err, reinit_req;
  logic [31:0] rdata;
  logic scan_req;
  logic [3:0] scan_ir;
  logic [2:0] scan_field;
  logic [31:0] scan_wdata;
  logic [BW-1:0] scan_idle;
  logic scan_done = 0;
  logic [2:0] scan_ack = 0;
  logic [31:0] scan_rdata = 0;

  always #10 clk = ~clk;

  dbg_txn_seq #(.MEM_IDLE(MIDLE), .TIMEOUT_CYC(100)) i_dbg_txn_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .ap_sel(ap_sel),
    .done(done), .err(err), .reinit_req(reinit_req), .rdata(rdata),
    .scan_req(scan_req), .scan_ir(scan_ir), .scan_field(scan_field),
    .scan_wdata(scan_wdata), .scan_idle(scan_idle), .scan_done(scan_done),
    .scan_ack(scan_ack), .scan_rdata(scan_rdata)
  );

  typedef struct {
    logic [3:0] ir; logic [2:0] fld; logic [31:0] wd; logic [7:0] idl;
    logic [2:0] ack; logic [31:0] rd;
  } scan_t;
  typedef struct { logic e; logic ri; logic chkd; logic [31:0] rd; } res_t;

  scan_t scan_q[$];
  string stag_q[$];
  res_t  res_q[$];
  string rtag_q[$];
  int nchk = 0, nfail = 0, n_loose = 0;
  bit loose = 0;

  task automatic chk(bit ok, string tag, string msg);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s: %s", tag, msg); end
  endtask

  task automatic xs(logic [3:0] ir, logic [2:0] fld, logic [31:0] wd, logic [7:0] idl,
                    logic [2:0] ack, logic [31:0] rd, string tag);
    scan_t s;
    s.ir = ir; s.fld = fld; s.wd = wd; s.idl = idl; s.ack = ack; s.rd = rd;
    scan_q.push_back(s); stag_q.push_back(tag);
  endtask

  task automatic xr(logic e, logic ri, logic chkd, logic [31:0] rd, string tag);
    res_t r;
    r.e = e; r.ri = ri; r.chkd = chkd; r.rd = rd;
    res_q.push_back(r); rtag_q.push_back(tag);
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] a, logic [31:0] wd, string tag);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    while (res_q.size() != 0) @(negedge clk);
    chk(scan_q.size() == 0, tag,
        $sformatf("pending scans actual %0d expected 0", scan_q.size()));
  endtask

  // shifter model: pops expected scans, compares, answers
  initial begin
    forever begin
      scan_t s;
      string t;
      logic [2:0] a;
      logic [31:0] d;
      @(negedge clk);
      scan_done = 0;
      if (scan_req && !rst) begin
        a = 3'b010; d = 0;
        if (scan_q.size() > 0) begin
          s = scan_q.pop_front(); t = stag_q.pop_front();
          chk(scan_ir == s.ir && scan_field == s.fld && scan_wdata == s.wd
              && 8'(scan_idle) == s.idl, t,
              $sformatf("scan actual ir=%h f=%b d=%h i=%0d expected ir=%h f=%b d=%h i=%0d",
                        scan_ir, scan_field, scan_wdata, scan_idle, s.ir, s.fld, s.wd, s.idl));
          a = s.ack; d = s.rd;
        end else if (loose) begin
          n_loose++;
          if (scan_ir != 4'hA) chk(0, "R7", $sformatf("poll ir actual %h expected a", scan_ir));
          a = 3'b001;
        end else begin
          chk(0, "R8", $sformatf("unexpected scan ir=%h f=%b expected none", scan_ir, scan_field));
        end
        repeat (2) @(negedge clk);
        scan_done = 1; scan_ack = a; scan_rdata = d;
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (res_q.size() == 0) chk(0, "R11", "unexpected done actual 1 expected 0");
      else begin
        res_t r;
        string t;
        r = res_q.pop_front(); t = rtag_q.pop_front();
        chk(err == r.e && reinit_req == r.ri && (!r.chkd || rdata == r.rd), t,
            $sformatf("result actual err=%b ri=%b rd=%h expected err=%b ri=%b rd=%h",
                      err, reinit_req, rdata, r.e, r.ri, r.rd));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !scan_req && !done, "R1",
        $sformatf("reset actual rdy=%b req=%b done=%b expected 1 0 0", cmd_ready, scan_req, done));

    // R2 DP write
    xs(4'hA, 3'b010, 32'hCAFE_0001, 0, 3'b010, 0, "R2");
    xr(0, 0, 0, 0, "R2");
    issue(3'd1, 8'h04, 32'hCAFE_0001, "R2");

    // R3 DP read
    xs(4'hA, 3'b001, 0, 0, 3'b010, 32'h1111_1111, "R3");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'h2BA0_1477, "R3");
    xr(0, 0, 1, 32'h2BA0_1477, "R3");
    issue(3'd0, 8'h00, 0, "R3");

    // R1 R4 R5 first AP write selects bank 0, memory-data idle
    xs(4'hA, 3'b100, 32'h0300_0000, 0, 3'b010, 0, "R1");
    xs(4'hB, 3'b110, 32'h1234_5678, MIDLE, 3'b010, 0, "R5");
    xr(0, 0, 0, 0, "R4");
    issue(3'd3, 8'h0C, 32'h1234_5678, "R4");

    // R4 same bank: no select; R5 no idle
    xs(4'hB, 3'b011, 0, 0, 3'b010, 0, "R4");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'h0000_A5A5, "R3");
    xr(0, 0, 1, 32'h0000_A5A5, "R3");
    issue(3'd2, 8'h04, 0, "R4");

    // R4 bank 1 select, R5 banked-data idle
    xs(4'hA, 3'b100, 32'h0300_0010, 0, 3'b010, 0, "R4");
    xs(4'hB, 3'b011, 0, MIDLE, 3'b010, 0, "R5");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'hBD14_0000, "R3");
    xr(0, 0, 1, 32'hBD14_0000, "R3");
    issue(3'd2, 8'h14, 0, "R4");

    // R4 bank 1 cached
    xs(4'hB, 3'b000, 32'h0000_00EE, MIDLE, 3'b010, 0, "R4");
    xr(0, 0, 0, 0, "R4");
    issue(3'd3, 8'h10, 32'h0000_00EE, "R4");

    // R6 clean check
    xs(4'hA, 3'b011, 0, 0, 3'b010, 0, "R6");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'hF000_0000, "R6");
    xr(0, 0, 0, 0, "R6");
    issue(3'd4, 0, 0, "R6");

    // R7 WAIT twice then OK
    for (int k = 0; k < 2; k++) begin
      xs(4'hA, 3'b011, 0, 0, 3'b010, 0, "R7");
      xs(4'hA, 3'b111, 0, 0, 3'b001, 0, "R7");
    end
    xs(4'hA, 3'b011, 0, 0, 3'b010, 0, "R7");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'hF000_0000, "R7");
    xr(0, 0, 0, 0, "R7");
    issue(3'd4, 0, 0, "R7");

    // R8 invalid ack
    xs(4'hA, 3'b011, 0, 0, 3'b010, 0, "R8");
    xs(4'hA, 3'b111, 0, 0, 3'b100, 0, "R8");
    xr(1, 0, 0, 0, "R8");
    issue(3'd4, 0, 0, "R8");

    // R9 sticky with power down
    xs(4'hA, 3'b011, 0, 0, 3'b010, 0, "R9");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'h5000_0020, "R9");
    xr(1, 1, 0, 0, "R9");
    issue(3'd4, 0, 0, "R9");

    // R10 sticky with power up; bank 1 cached so bank 0 select needed
    xs(4'hA, 3'b011, 0, 0, 3'b010, 0, "R10");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'hF000_0002, "R10");
    xs(4'hA, 3'b010, 32'hF000_0022, 0, 3'b010, 0, "R10");
    xs(4'hA, 3'b011, 0, 0, 3'b010, 0, "R10");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'hF000_0000, "R10");
    xs(4'hA, 3'b100, 32'h0300_0000, 0, 3'b010, 0, "R10");
    xs(4'hB, 3'b001, 0, 0, 3'b010, 0, "R10");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'h2300_0052, "R10");
    xs(4'hB, 3'b011, 0, 0, 3'b010, 0, "R10");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'h2000_0100, "R10");
    xr(1, 0, 0, 0, "R10");
    issue(3'd4, 0, 0, "R10");

    // R4 bank 0 cached by the diagnostic select
    xs(4'hB, 3'b001, 0, 0, 3'b010, 0, "R4");
    xs(4'hA, 3'b111, 0, 0, 3'b010, 32'h0000_0042, "R3");
    xr(0, 0, 1, 32'h0000_0042, "R4");
    issue(3'd2, 8'h00, 0, "R4");

    // R7 timeout under endless WAIT
    loose = 1;
    xr(1, 0, 0, 0, "R7");
    issue(3'd4, 0, 0, "R7");
    loose = 0;
    chk(n_loose >= 4, "R7", $sformatf("polls actual %0d expected >=4", n_loose));

    // R11 illegal op
    xr(1, 0, 0, 0, "R11");
    issue(3'd6, 0, 0, "R11");

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule